// File: doc/BRIEF.md
# Bad-Block-Skipping Page Translator

This block turns a logical read request, given as a starting logical page and a length in bytes, into a series of physical page-range read requests for a flash array divided into erase blocks. Bad erase blocks are invisible to the logical address space: they are stepped over both while the logical offset is being located and while data is being read. Every read request stays inside one erase block. The block emits each request as a start page and a page count and waits for it to be accepted and completed. When the sequence ends it reports the number of bytes read.

The good or bad verdict for each erase block comes from an external marker checker through a request/acknowledge pair. The first sixteen blocks have a small verdict cache, so each of them is checked at most once between resets. Pages per block and page size are powers of two, given as log2 values when the operation starts. The flash access itself and the data movement belong to neighbouring blocks.

Top module: `bbx_page_translator`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `probe_req` and `rd_valid` are low and `bytes_read` is zero. All verdict cache entries hold the unknown code 0xFF, so the first visit to any block asks the checker.
- R2: A block with index below 16 whose verdict has already been learned is never probed again. A block with index 16 or above is probed on every visit.
- R3: An acknowledged probe stores its verdict in the cache entry for blocks below 16 (code 0x01 for `probe_bad`=1, code 0x00 for `probe_bad`=0), and later visits use the stored verdict.
- R4: The number of good blocks passed over before reading is `start_lpage >> cfg_ppb_log2`. Bad blocks are passed over without reducing that count. The page offset inside the first read block is the low `cfg_ppb_log2` bits of `start_lpage`.
- R5: The pages to read total ceil(`start_len` / 2^`cfg_pg_log2`). Each request counts min(2^`cfg_ppb_log2` − offset, pages still to read) pages.
- R6: A request starts at physical page (block index << `cfg_ppb_log2`) + offset. The offset is zero for every request after the first. Bad blocks met during reading are skipped, and the next request goes to the next good block.
- R7: A completion with `rd_err` high ends the sequence, and the failing request adds no bytes. `bytes_read` equals min(`start_len`, bytes of the requests that completed without error).
- R8: `done` is high for exactly one cycle at the end of an operation. `bytes_read` is valid in that cycle and keeps its value until the next operation ends.
- R9: While `rd_valid` is high and `rd_ready` is low, `rd_valid`, `rd_page` and `rd_count` hold their values.
- R10: While `probe_req` is high and `probe_ack` is low, `probe_req` and `probe_blk` hold their values.
- R11: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| start_lpage | input | PAGE_W | First logical page |
| start_len | input | LEN_W | Length in bytes |
| cfg_ppb_log2 | input | LOG_W | log2 of pages per erase block, at most MAX_PPB_LOG2 |
| cfg_pg_log2 | input | LOG_W | log2 of page size in bytes, at most MAX_PG_LOG2 |
| probe_req | output | 1 | Marker check wanted for `probe_blk` |
| probe_blk | output | BLK_W | Erase block to check |
| probe_ack | input | 1 | Marker check answered this cycle |
| probe_bad | input | 1 | Answer: 1 when the block is bad |
| rd_valid | output | 1 | Read request offered |
| rd_page | output | PAGE_W | Physical start page of the request |
| rd_count | output | CNT_W | Pages in the request |
| rd_ready | input | 1 | Request accepted this cycle |
| rd_cpl | input | 1 | Accepted request has finished |
| rd_err | input | 1 | Finished request failed (with `rd_cpl`) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| bytes_read | output | LEN_W | Bytes delivered by the last operation |

## Verification
The bench uses 8-bit block indices, pages per block up to 2^6 and page sizes up to 64 bytes. Pages per block can then be as small as one, which makes every page its own request, and random lengths still span twenty or more erase blocks. A 256-entry bench bad-block map covers both the cached blocks below 16 and the always-probed blocks above them. Repeated operations between resets therefore show the cache saving probes in the low range and not in the high range.

// File: rtl/bbx_pkg.sv
package bbx_pkg;

   localparam int VCODE_W = 8;
   localparam logic [VCODE_W-1:0] VC_UNKNOWN = 8'hFF;
   localparam logic [VCODE_W-1:0] VC_GOOD    = 8'h00;
   localparam logic [VCODE_W-1:0] VC_BAD     = 8'h01;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOKUP,
      ST_PROBE,
      ST_ISSUE,
      ST_WAIT,
      ST_FINISH
   } bbx_state_e;

endpackage

// File: rtl/bbx_verdict_cache.sv
module bbx_verdict_cache
   import bbx_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int BLK_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BLK_W-1:0] lk_blk,
   output logic             lk_hit,
   output logic             lk_bad,
   input  logic             wr_en,
   input  logic [BLK_W-1:0] wr_blk,
   input  logic             wr_bad
);

   if (!(DEPTH == 0 || (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0))) begin : g_bad_depth
      $error("bbx_verdict_cache: DEPTH must be 0 or a power of two of at least 2");
   end
   if (DEPTH >= (1 << BLK_W)) begin : g_bad_span
      $error("bbx_verdict_cache: DEPTH must be below the block index range");
   end

   if (DEPTH == 0) begin : g_nocache
      logic unused_nc;
      assign unused_nc = ^{clk, rst_n, lk_blk, wr_en, wr_blk, wr_bad};
      assign lk_hit = 1'b0;
      assign lk_bad = 1'b0;
   end else begin : g_cache
      localparam int IDX_W = $clog2(DEPTH);

      logic [VCODE_W-1:0] code_q [DEPTH];
      logic [VCODE_W-1:0] lk_code;
      logic               lk_in_rng;
      logic               wr_in_rng;

      always_ff @(posedge clk) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
               code_q[i] <= VC_UNKNOWN;
            end else if (wr_en && wr_blk == BLK_W'(i)) begin
               code_q[i] <= wr_bad ? VC_BAD : VC_GOOD;
            end
         end
      end

      assign lk_in_rng = {1'b0, lk_blk} < (BLK_W + 1)'(DEPTH);
      assign wr_in_rng = {1'b0, wr_blk} < (BLK_W + 1)'(DEPTH);
      assign lk_code   = code_q[lk_blk[IDX_W-1:0]];
      assign lk_hit    = lk_in_rng && (lk_code != VC_UNKNOWN);
      assign lk_bad    = (lk_code == VC_BAD);

      // R3: a stored verdict is returned on the very next lookup of that block
      p_write_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_in_rng) |=>
            ((lk_blk != $past(wr_blk)) || (lk_hit && (lk_bad == $past(wr_bad)))));
   end

endmodule

// File: rtl/bbx_span_calc.sv
module bbx_span_calc #(
   parameter int BLK_W  = 16,
   parameter int OFF_W  = 10,
   parameter int LOG_W  = 4,
   parameter int LEFT_W = 24,
   parameter int CNT_W  = 11
) (
   input  logic [BLK_W-1:0]         blk,
   input  logic [OFF_W-1:0]         off,
   input  logic [LEFT_W-1:0]        left,
   input  logic [LOG_W-1:0]         ppb_log2,
   output logic [BLK_W+OFF_W-1:0]   page,
   output logic [CNT_W-1:0]         count
);

   localparam int PAGE_W = BLK_W + OFF_W;
   localparam int CMP_W  = (LEFT_W > CNT_W) ? LEFT_W : CNT_W;

   if (CNT_W != OFF_W + 1) begin : g_bad_cnt
      $error("bbx_span_calc: CNT_W must be OFF_W + 1");
   end

   logic [CMP_W-1:0] room;
   logic [CMP_W-1:0] left_w;
   logic [CMP_W-1:0] pick;

   assign room   = (CMP_W'(1) << ppb_log2) - CMP_W'(off);
   assign left_w = CMP_W'(left);
   assign pick   = (left_w < room) ? left_w : room;
   assign count  = pick[CNT_W-1:0];
   assign page   = (PAGE_W'(blk) << ppb_log2) | PAGE_W'(off);

endmodule

// File: rtl/bbx_page_translator.sv
module bbx_page_translator
   import bbx_pkg::*;
#(
   parameter int BLK_W        = 16,
   parameter int LEN_W        = 24,
   parameter int MAX_PPB_LOG2 = 10,
   parameter int MAX_PG_LOG2  = 13,
   parameter int CACHE_DEPTH  = 16,
   localparam int OFF_W   = MAX_PPB_LOG2,
   localparam int PAGE_W  = BLK_W + OFF_W,
   localparam int CNT_W   = MAX_PPB_LOG2 + 1,
   localparam int LOG_MAX = (MAX_PG_LOG2 > MAX_PPB_LOG2) ? MAX_PG_LOG2 : MAX_PPB_LOG2,
   localparam int LOG_W   = $clog2(LOG_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [PAGE_W-1:0] start_lpage,
   input  logic [LEN_W-1:0]  start_len,
   input  logic [LOG_W-1:0]  cfg_ppb_log2,
   input  logic [LOG_W-1:0]  cfg_pg_log2,
   output logic              probe_req,
   output logic [BLK_W-1:0]  probe_blk,
   input  logic              probe_ack,
   input  logic              probe_bad,
   output logic              rd_valid,
   output logic [PAGE_W-1:0] rd_page,
   output logic [CNT_W-1:0]  rd_count,
   input  logic              rd_ready,
   input  logic              rd_cpl,
   input  logic              rd_err,
   output logic              busy,
   output logic              done,
   output logic [LEN_W-1:0]  bytes_read
);

   localparam int LEFT_W = LEN_W;
   localparam int XFER_W = LEN_W + 2;

   if (MAX_PPB_LOG2 < 1) begin : g_bad_ppb
      $error("bbx_page_translator: MAX_PPB_LOG2 must be at least 1");
   end
   if (MAX_PG_LOG2 >= LEN_W) begin : g_bad_pg
      $error("bbx_page_translator: MAX_PG_LOG2 must be below LEN_W");
   end
   if (BLK_W < 2) begin : g_bad_blk
      $error("bbx_page_translator: BLK_W must be at least 2");
   end

   bbx_state_e         state_q;
   logic [PAGE_W-1:0]  skip_q;
   logic [OFF_W-1:0]   off_q;
   logic [LEFT_W-1:0]  left_q;
   logic [BLK_W-1:0]   blk_q;
   logic [XFER_W-1:0]  xfer_q;
   logic [LEN_W-1:0]   len_q;
   logic [LEN_W-1:0]   bytes_q;
   logic [LOG_W-1:0]   ppb_q;
   logic [LOG_W-1:0]   pg_q;

   logic               lk_hit;
   logic               lk_bad;
   logic               vbad;
   logic               nothing_left;
   logic [LEN_W-1:0]   cap_bytes;
   logic [LEN_W:0]     pages_needed;
   logic [OFF_W-1:0]   start_off;
   logic [OFF_W-1:0]   off_mask_q;
   logic [PAGE_W-1:0]  span_page;
   logic [CNT_W-1:0]   span_cnt;

   // ---------------- verdict cache ----------------
   bbx_verdict_cache #(
      .DEPTH (CACHE_DEPTH),
      .BLK_W (BLK_W)
   ) u_cache (
      .clk    (clk),
      .rst_n  (rst_n),
      .lk_blk (blk_q),
      .lk_hit (lk_hit),
      .lk_bad (lk_bad),
      .wr_en  (state_q == ST_PROBE && probe_ack),
      .wr_blk (blk_q),
      .wr_bad (probe_bad)
   );

   // ---------------- request geometry ----------------
   bbx_span_calc #(
      .BLK_W  (BLK_W),
      .OFF_W  (OFF_W),
      .LOG_W  (LOG_W),
      .LEFT_W (LEFT_W),
      .CNT_W  (CNT_W)
   ) u_span (
      .blk      (blk_q),
      .off      (off_q),
      .left     (left_q),
      .ppb_log2 (ppb_q),
      .page     (span_page),
      .count    (span_cnt)
   );

   // ---------------- derived terms ----------------
   assign pages_needed = ({1'b0, start_len} + ((LEN_W + 1)'(1) << cfg_pg_log2) - (LEN_W + 1)'(1))
                         >> cfg_pg_log2;
   assign start_off    = start_lpage[OFF_W-1:0] & ((OFF_W'(1) << cfg_ppb_log2) - OFF_W'(1));
   assign off_mask_q   = (OFF_W'(1) << ppb_q) - OFF_W'(1);
   assign nothing_left = (skip_q == '0) && (left_q == '0);
   assign cap_bytes    = (xfer_q > XFER_W'(len_q)) ? len_q : xfer_q[LEN_W-1:0];
   assign vbad         = (state_q == ST_PROBE) ? probe_bad : lk_bad;

   // ---------------- sequencer ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         skip_q  <= '0;
         off_q   <= '0;
         left_q  <= '0;
         blk_q   <= '0;
         xfer_q  <= '0;
         len_q   <= '0;
         bytes_q <= '0;
         ppb_q   <= '0;
         pg_q    <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  ppb_q   <= cfg_ppb_log2;
                  pg_q    <= cfg_pg_log2;
                  skip_q  <= start_lpage >> cfg_ppb_log2;
                  off_q   <= start_off;
                  left_q  <= pages_needed[LEFT_W-1:0];
                  blk_q   <= '0;
                  xfer_q  <= '0;
                  len_q   <= start_len;
                  state_q <= ST_LOOKUP;
               end
            end
            ST_LOOKUP, ST_PROBE: begin
               if (state_q == ST_LOOKUP && nothing_left) begin
                  bytes_q <= cap_bytes;
                  state_q <= ST_FINISH;
               end else if (state_q == ST_LOOKUP && !lk_hit) begin
                  state_q <= ST_PROBE;
               end else if (state_q == ST_LOOKUP || probe_ack) begin
                  if (skip_q != '0) begin
                     if (!vbad) skip_q <= skip_q - PAGE_W'(1);
                     blk_q   <= blk_q + BLK_W'(1);
                     state_q <= ST_LOOKUP;
                  end else if (vbad) begin
                     blk_q   <= blk_q + BLK_W'(1);
                     state_q <= ST_LOOKUP;
                  end else begin
                     state_q <= ST_ISSUE;
                  end
               end
            end
            ST_ISSUE: begin
               if (rd_ready) state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (rd_cpl) begin
                  if (rd_err) begin
                     bytes_q <= cap_bytes;
                     state_q <= ST_FINISH;
                  end else begin
                     xfer_q  <= xfer_q + (XFER_W'(span_cnt) << pg_q);
                     left_q  <= left_q - LEFT_W'(span_cnt);
                     off_q   <= '0;
                     blk_q   <= blk_q + BLK_W'(1);
                     state_q <= ST_LOOKUP;
                  end
               end
            end
            ST_FINISH: begin
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy       = (state_q != ST_IDLE);
   assign done       = (state_q == ST_FINISH);
   assign probe_req  = (state_q == ST_PROBE);
   assign probe_blk  = blk_q;
   assign rd_valid   = (state_q == ST_ISSUE);
   assign rd_page    = span_page;
   assign rd_count   = span_cnt;
   assign bytes_read = bytes_q;

   // ---------------- assertions ----------------
   // R2: a probe is only raised after a lookup that missed the cache
   p_probe_on_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(probe_req) |-> !$past(lk_hit));

   // R5: a request moves at least one and at most one block of pages
   p_count_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (rd_count != '0) && (32'(rd_count) <= (32'(1) << ppb_q)));

   // R6: a request never crosses an erase-block boundary
   p_in_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (32'(rd_page[OFF_W-1:0] & off_mask_q) + 32'(rd_count)) <= (32'(1) << ppb_q));

   // R7: the reported byte count never exceeds the requested length
   p_bytes_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> bytes_read <= len_q);

   // R8: done lasts a single cycle and the result then holds
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && $stable(bytes_read));

   // R9: an offered request holds until accepted
   p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> rd_valid && $stable(rd_page) && $stable(rd_count));

   // R10: a probe holds until acknowledged
   p_probe_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (probe_req && !probe_ack) |=> probe_req && $stable(probe_blk));

   // R11: a start seen while busy does not restart the operation
   p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && start) |=> busy);

endmodule

// File: tb/test_bbx_page_translator.sv
module test_bbx_page_translator;

   localparam int CLK_NS       = 10;
   localparam int BLK_W        = 8;
   localparam int LEN_W        = 20;
   localparam int MAX_PPB_LOG2 = 6;
   localparam int MAX_PG_LOG2  = 6;
   localparam int CACHE_DEPTH  = 16;
   localparam int PAGE_W       = BLK_W + MAX_PPB_LOG2;
   localparam int CNT_W        = MAX_PPB_LOG2 + 1;
   localparam int LOG_MAX      = (MAX_PG_LOG2 > MAX_PPB_LOG2) ? MAX_PG_LOG2 : MAX_PPB_LOG2;
   localparam int LOG_W        = $clog2(LOG_MAX + 1);
   localparam int NBLK         = 1 << BLK_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [PAGE_W-1:0] start_lpage = '0;
   logic [LEN_W-1:0]  start_len = '0;
   logic [LOG_W-1:0]  cfg_ppb_log2 = '0;
   logic [LOG_W-1:0]  cfg_pg_log2 = '0;
   logic              probe_req;
   logic [BLK_W-1:0]  probe_blk;
   logic              probe_ack = 1'b0;
   logic              probe_bad = 1'b0;
   logic              rd_valid;
   logic [PAGE_W-1:0] rd_page;
   logic [CNT_W-1:0]  rd_count;
   logic              rd_ready = 1'b0;
   logic              rd_cpl = 1'b0;
   logic              rd_err = 1'b0;
   logic              busy;
   logic              done;
   logic [LEN_W-1:0]  bytes_read;

   bbx_page_translator #(
      .BLK_W        (BLK_W),
      .LEN_W        (LEN_W),
      .MAX_PPB_LOG2 (MAX_PPB_LOG2),
      .MAX_PG_LOG2  (MAX_PG_LOG2),
      .CACHE_DEPTH  (CACHE_DEPTH)
   ) i_bbx_page_translator (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .start_lpage  (start_lpage),
      .start_len    (start_len),
      .cfg_ppb_log2 (cfg_ppb_log2),
      .cfg_pg_log2  (cfg_pg_log2),
      .probe_req    (probe_req),
      .probe_blk    (probe_blk),
      .probe_ack    (probe_ack),
      .probe_bad    (probe_bad),
      .rd_valid     (rd_valid),
      .rd_page      (rd_page),
      .rd_count     (rd_count),
      .rd_ready     (rd_ready),
      .rd_cpl       (rd_cpl),
      .rd_err       (rd_err),
      .busy         (busy),
      .done         (done),
      .bytes_read   (bytes_read)
   );

   always #(CLK_NS / 2) clk = ~clk;

   int n_chk  = 0;
   int n_fail = 0;

   bit bad_map [NBLK];
   int mcache [16];
   int exp_page [256];
   int exp_cnt [256];
   int exp_probe [1024];
   int n_exp;
   int n_exp_probe;
   int exp_bytes;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   // verdict as the requirements define it, with its own cache model
   function automatic int m_bad(input int b);
      int v;
      if (b < 16 && mcache[b] != 255) return mcache[b];
      exp_probe[n_exp_probe] = b;
      n_exp_probe++;
      v = int'(bad_map[b % NBLK]);
      if (b < 16) mcache[b] = v;
      return v;
   endfunction

   task automatic ref_model(input int lpage, input int len, input int pl, input int gl,
                            input int err_idx);
      int ppb, skip, off, left, blk, xfer, cnt;
      ppb  = 1 << pl;
      skip = lpage >> pl;
      off  = lpage & (ppb - 1);
      left = (len + (1 << gl) - 1) >> gl;
      blk  = 0;
      xfer = 0;
      n_exp = 0;
      n_exp_probe = 0;
      while (skip != 0) begin
         if (m_bad(blk) == 0) skip--;
         blk++;
      end
      while (left != 0) begin
         if (m_bad(blk) != 0) begin
            blk++;
         end else begin
            cnt = (ppb - off < left) ? ppb - off : left;
            exp_page[n_exp] = blk * ppb + off;
            exp_cnt[n_exp]  = cnt;
            n_exp++;
            if (n_exp - 1 == err_idx) break;
            blk++;
            off = 0;
            xfer += cnt << gl;
            left -= cnt;
         end
      end
      exp_bytes = (xfer < len) ? xfer : len;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      start = 1'b0;
      probe_ack = 1'b0;
      rd_ready = 1'b0;
      rd_cpl = 1'b0;
      rd_err = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 16; i++) mcache[i] = 255;
      chk(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
      chk(!probe_req && !rd_valid, "R1", "probe_req/rd_valid after reset", {probe_req, rd_valid}, 0);
      chk(bytes_read == '0, "R1", "bytes_read after reset", bytes_read, 0);
   endtask

   task automatic run_op(input int lpage, input int len, input int pl, input int gl,
                         input int err_idx, input bit poke);
      int  nreq, nprb, it;
      bit  fin, pend;
      ref_model(lpage, len, pl, gl, err_idx);
      @(negedge clk);
      start        = 1'b1;
      start_lpage  = PAGE_W'(lpage);
      start_len    = LEN_W'(len);
      cfg_ppb_log2 = LOG_W'(pl);
      cfg_pg_log2  = LOG_W'(gl);
      nreq = 0; nprb = 0; it = 0; fin = 0; pend = 0;
      while (!fin) begin
         @(negedge clk);
         start     = 1'b0;
         probe_ack = 1'b0;
         rd_ready  = 1'b0;
         rd_cpl    = 1'b0;
         rd_err    = 1'b0;
         it++;
         if (poke && it == 3) begin
            // R11: a second start with other values while busy
            start       = 1'b1;
            start_lpage = PAGE_W'(lpage + 77);
            start_len   = LEN_W'(5);
         end
         if (done) begin
            chk(bytes_read == LEN_W'(exp_bytes), "R7", "bytes_read", bytes_read, exp_bytes);
            chk(nreq == n_exp, "R6", "number of requests", nreq, n_exp);
            chk(nprb == n_exp_probe, "R2", "number of probes", nprb, n_exp_probe);
            fin = 1;
         end else if (probe_req) begin
            if ($urandom % 3 != 0) begin
               chk(nprb < n_exp_probe && int'(probe_blk) == exp_probe[nprb % 1024], "R2",
                   "probed block", probe_blk, (nprb < n_exp_probe) ? exp_probe[nprb] : -1);
               probe_bad = bad_map[probe_blk];
               probe_ack = 1'b1;
               nprb++;
            end
         end else if (rd_valid) begin
            if ($urandom % 2 == 0) begin
               chk(nreq < n_exp && int'(rd_page) == exp_page[nreq % 256], "R6", "rd_page",
                   rd_page, (nreq < n_exp) ? exp_page[nreq] : -1);
               chk(nreq < n_exp && int'(rd_count) == exp_cnt[nreq % 256], "R5", "rd_count",
                   rd_count, (nreq < n_exp) ? exp_cnt[nreq] : -1);
               rd_ready = 1'b1;
               pend = 1;
               nreq++;
            end
         end else if (pend) begin
            if ($urandom % 2 == 0) begin
               rd_cpl = 1'b1;
               rd_err = (nreq - 1 == err_idx);
               pend = 0;
            end
         end
      end
      @(negedge clk);
      start = 1'b0;
      chk(!done && bytes_read == LEN_W'(exp_bytes), "R8", "done pulse / held bytes",
          {done, bytes_read}, exp_bytes);
   endtask

   initial begin
      int pl, gl, lp, ln, ei;
      void'($urandom(32'd20240611));

      // group 1: fixed bad blocks in both ranges
      for (int b = 0; b < NBLK; b++) bad_map[b] = (b >= 20) && ($urandom % 7 == 0);
      bad_map[0] = 1; bad_map[2] = 1; bad_map[5] = 1; bad_map[17] = 1; bad_map[18] = 1;
      do_reset();

      run_op(0, 0, 2, 4, -1, 0);             // R4: nothing to skip, nothing to read
      run_op(15, 48, 2, 4, -1, 0);           // R4 R6: offset 3, bad blocks skipped
      run_op(15, 48, 2, 4, -1, 0);           // R2 R3: cached blocks not probed again
      run_op(4, 50, 2, 4, -1, 0);            // R5 R7: partial last page
      run_op(0, 200, 1, 3, 1, 0);            // R7: error on second request
      run_op(8, 64, 2, 4, 0, 0);             // R7: error on first request
      run_op(16 << 2, 40, 2, 3, -1, 0);      // R2: blocks 17/18 probed
      run_op(16 << 2, 40, 2, 3, -1, 0);      // R2: probed again above 16
      run_op(3, 640, 0, 4, -1, 1);           // R11 R5: one page per block, start while busy
      run_op(63, 64 * 64 * 3, 6, 6, -1, 0);  // R5: maximum block and page size

      for (int k = 0; k < 30; k++) begin
         pl = $urandom % (MAX_PPB_LOG2 + 1);
         gl = 2 + $urandom % (MAX_PG_LOG2 - 1);
         lp = $urandom % ((12 << pl) + 1);
         ln = $urandom % (((20 << pl) << gl) + 1);
         ei = ($urandom % 5 == 0) ? int'($urandom % 3) : -1;
         run_op(lp, ln, pl, gl, ei, k % 7 == 3);
      end

      // group 2: new random map after a fresh reset (R1: cache forgotten)
      for (int b = 0; b < NBLK; b++) bad_map[b] = ($urandom % 5 == 0);
      do_reset();
      for (int k = 0; k < 20; k++) begin
         pl = $urandom % (MAX_PPB_LOG2 + 1);
         gl = 2 + $urandom % (MAX_PG_LOG2 - 1);
         lp = $urandom % ((12 << pl) + 1);
         ln = $urandom % (((20 << pl) << gl) + 1);
         ei = ($urandom % 5 == 0) ? int'($urandom % 3) : -1;
         run_op(lp, ln, pl, gl, ei, 1'b0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule